// File: doc/BRIEF.md
# Hardware Thread Context Manager

This block keeps the control state of a small pool of hardware thread contexts that all belong to processors selected by a per-context binding field. Each context carries an allocatable flag, an active flag, a halt flag, a dirty flag, a delay-slot flag, a two-bit run state, a two-bit privilege mode, an address-space identifier and a restart program counter. One issuing context at a time presents a fork, yield, halt or restore request. The block updates the pool and reports completion with a fault flag and a thread exception code.

A fork looks for a free context. It scans the pool from index 0 upward over the configured number of contexts and takes the first one that sits on the requester's processor, is allocatable, is not halted and is not active. It writes the child's restart PC and emits a register-file write for the child. A yield can deactivate the caller, or it can fault on bad operands, and it always returns the source ANDed with the mask. Halt parks an active context and stores its next PC. Restore reactivates a parked context and hands its stored PC back.

Top module: `thread_ctx_mgr`

## Requirements
- R1: After reset no context is active, halted or dirty, and every context is allocatable. Status word of a context, `peek_stat` = {alloc[16], active[15], halted[14], dirty[13], delay_slot[12], run_state[11:10], mode[9:8], asid[7:0]}. After reset `done` and `exc_code` are 0.
- R2: A request is sampled with `req_valid` high on a rising edge (E0). All of its state changes take effect on the next edge (E1). `done` is high for exactly the one cycle after E1. The next request may be raised no earlier than the cycle in which `done` is high.
- R3: Fork (`req_op`=0) chooses the lowest-indexed context that is bound to the same processor as `req_ctx` in `ctx_vpe` (two bits per context, context i in bits [2i+1:2i]). The chosen context must also be allocatable, not halted and not active.
- R4: Only contexts 0 to `cfg_max` are considered by the fork scan.
- R5: A successful fork pulses `wr_en` with `wr_ctx` = the chosen context, `wr_rd` = `req_rd` and `wr_data` = `req_b`. It stores `req_a` as the chosen context's restart PC.
- R6: A successful fork leaves the child with active=1, dirty=1, delay_slot=0 and run_state=0. The child takes its mode from `req_mode` and its asid from `req_asid`.
- R7: A fork that finds no candidate raises `fault` with `exc_code`=1. It changes no context and does not pulse `wr_en`.
- R8: A yield (`req_op`=1) with source 0 clears the caller's active flag, but only if the caller is allocatable, not halted and active. Otherwise it has no effect.
- R9: A yield with a positive source faults with `exc_code`=2 when the mask is zero. With a non-zero mask it does not fault.
- R10: A yield with a negative source other than -2 faults with `exc_code`=4 when `cfg_ysi` is 1 and the caller is dirty. A source of -2 never faults.
- R11: Every yield returns `yield_res` = `req_src` & `req_mask`.
- R12: Halt (`req_op`=2) of an active context makes it inactive and halted and stores `req_a` as its restart PC. Halt of an inactive context changes nothing. A context is never both halted and active.
- R13: Restore (`req_op`=3) of an inactive context makes it active and not halted, and pulses `resume_en` with `resume_pc` = its restart PC. Restore of an active context changes nothing and leaves `resume_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 2 | 0 fork, 1 yield, 2 halt, 3 restore |
| req_ctx | input | IDX_W | Caller (fork, yield) or target (halt, restore) |
| req_a | input | PC_W | Child restart PC (fork) or next PC (halt) |
| req_b | input | DATA_W | Value written to the child's register on fork |
| req_rd | input | REG_W | Child destination register on fork |
| req_src | input | DATA_W | Signed yield source |
| req_mask | input | DATA_W | Yield mask |
| req_mode | input | 2 | Caller privilege mode, copied to a forked child |
| req_asid | input | 8 | Caller asid, copied to a forked child |
| cfg_max | input | IDX_W | Highest context index scanned by fork |
| cfg_ysi | input | 1 | Enables the negative-source yield fault |
| alloc_mask | input | NCTX | Per-context allocatable flags, registered every cycle |
| ctx_vpe | input | NCTX*VPE_W | Per-context processor binding |
| peek_ctx | input | IDX_W | Context whose status word appears on peek_stat |
| done | output | 1 | Request completed |
| fault | output | 1 | Request raised a thread fault |
| exc_code | output | 3 | Thread exception code, 0 when no fault |
| yield_res | output | DATA_W | Yield result |
| wr_en | output | 1 | Child register write strobe |
| wr_ctx | output | IDX_W | Child context index |
| wr_rd | output | REG_W | Child register index |
| wr_data | output | DATA_W | Child register value |
| resume_en | output | 1 | Restore reloaded a PC |
| resume_pc | output | PC_W | Reloaded PC |
| ctx_active | output | NCTX | Active flag per context |
| ctx_halted | output | NCTX | Halt flag per context |
| peek_stat | output | 17 | Status word of peek_ctx, one cycle after selection |

## Verification
The bench targets the fork scan at every point where a candidate can be disqualified: an active context, a cleared allocatable flag, a halted context, a different processor binding, and an index above `cfg_max`. A scanner that ignored any one of these would pick a wrong child or miss the exception-1 fault. Restart PCs go through a fork and then a restore, and through a halt and then a restore. A design that stored the wrong operand, or wrote to the wrong slot, would return the wrong `resume_pc`. The yield cases cover the zero-mask fault, the -2 exemption, the clean-caller case and the disabled-enable case, so that wrong comparisons or a missing dirty check produce a spurious fault or a missing one. Halting an inactive context and restoring an active one must leave the activity vectors untouched.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int MODE_W = 2;
  localparam int RUN_W  = 2;
  localparam int ASID_W = 8;
  localparam int EXC_W  = 3;

  typedef enum logic [1:0] {
    OP_FORK    = 2'd0,
    OP_YIELD   = 2'd1,
    OP_HALT    = 2'd2,
    OP_RESTORE = 2'd3
  } tcm_op_e;

  localparam logic [EXC_W-1:0] EXC_NONE   = 3'd0;
  localparam logic [EXC_W-1:0] EXC_NOFREE = 3'd1;
  localparam logic [EXC_W-1:0] EXC_YMASK  = 3'd2;
  localparam logic [EXC_W-1:0] EXC_YSCHED = 3'd4;

  typedef struct packed {
    logic              alloc;
    logic              act;
    logic              halt;
    logic              dirty;
    logic              tds;
    logic [RUN_W-1:0]  run;
    logic [MODE_W-1:0] mode;
    logic [ASID_W-1:0] asid;
  } ctx_stat_t;

  localparam int STAT_W = $bits(ctx_stat_t);
endpackage

// File: rtl/tcm_prio_scan.sv
module tcm_prio_scan #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  cand,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest set index wins: walk downward so the last hit is the smallest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tcm_pc_ram.sv
module tcm_pc_ram #(
  parameter int DEPTH = 4,
  parameter int W     = 32,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/thread_ctx_mgr.sv
module thread_ctx_mgr
  import tcm_pkg::*;
#(
  parameter int NCTX   = 4,
  parameter int VPE_W  = 2,
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  localparam int IDX_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [1:0]            req_op,
  input  logic [IDX_W-1:0]      req_ctx,
  input  logic [PC_W-1:0]       req_a,
  input  logic [DATA_W-1:0]     req_b,
  input  logic [REG_W-1:0]      req_rd,
  input  logic [DATA_W-1:0]     req_src,
  input  logic [DATA_W-1:0]     req_mask,
  input  logic [MODE_W-1:0]     req_mode,
  input  logic [ASID_W-1:0]     req_asid,
  input  logic [IDX_W-1:0]      cfg_max,
  input  logic                  cfg_ysi,
  input  logic [NCTX-1:0]       alloc_mask,
  input  logic [NCTX*VPE_W-1:0] ctx_vpe,
  input  logic [IDX_W-1:0]      peek_ctx,
  output logic                  done,
  output logic                  fault,
  output logic [EXC_W-1:0]      exc_code,
  output logic [DATA_W-1:0]     yield_res,
  output logic                  wr_en,
  output logic [IDX_W-1:0]      wr_ctx,
  output logic [REG_W-1:0]      wr_rd,
  output logic [DATA_W-1:0]     wr_data,
  output logic                  resume_en,
  output logic [PC_W-1:0]       resume_pc,
  output logic [NCTX-1:0]       ctx_active,
  output logic [NCTX-1:0]       ctx_halted,
  output logic [STAT_W-1:0]     peek_stat
);

  // ---------------- request capture (stage E0) ----------------
  logic              s_vld;
  tcm_op_e           s_op;
  logic [IDX_W-1:0]  s_ctx;
  logic [PC_W-1:0]   s_a;
  logic [DATA_W-1:0] s_b;
  logic [REG_W-1:0]  s_rd;
  logic [DATA_W-1:0] s_src;
  logic [DATA_W-1:0] s_mask;
  logic [MODE_W-1:0] s_mode;
  logic [ASID_W-1:0] s_asid;

  always_ff @(posedge clk) begin
    if (rst) s_vld <= 1'b0;
    else     s_vld <= req_valid;
    if (req_valid) begin
      s_op   <= tcm_op_e'(req_op);
      s_ctx  <= req_ctx;
      s_a    <= req_a;
      s_b    <= req_b;
      s_rd   <= req_rd;
      s_src  <= req_src;
      s_mask <= req_mask;
      s_mode <= req_mode;
      s_asid <= req_asid;
    end
  end

  // ---------------- context state ----------------
  ctx_stat_t st_q [NCTX];

  // ---------------- fork candidate scan ----------------
  logic [VPE_W-1:0] caller_vpe;
  logic [NCTX-1:0]  cand;
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;

  always_comb caller_vpe = ctx_vpe[int'(s_ctx)*VPE_W +: VPE_W];

  for (genvar g = 0; g < NCTX; g++) begin : g_cand
    assign cand[g] = (g <= int'(cfg_max))
                   && (ctx_vpe[g*VPE_W +: VPE_W] == caller_vpe)
                   && st_q[g].alloc && !st_q[g].halt && !st_q[g].act;
  end

  tcm_prio_scan #(.N(NCTX), .IW(IDX_W)) u_scan (
    .cand  (cand),
    .found (pick_found),
    .idx   (pick_idx)
  );

  // ---------------- execute decisions (stage E1) ----------------
  logic is_fork, is_yield, is_halt, is_rest;
  logic fork_ok, fork_bad, y_clear, y_mask_f, y_sched_f, halt_ok, rest_ok;
  ctx_stat_t caller;

  always_comb begin
    caller    = st_q[s_ctx];
    is_fork   = s_vld && (s_op == OP_FORK);
    is_yield  = s_vld && (s_op == OP_YIELD);
    is_halt   = s_vld && (s_op == OP_HALT);
    is_rest   = s_vld && (s_op == OP_RESTORE);
    fork_ok   = is_fork && pick_found;
    fork_bad  = is_fork && !pick_found;
    y_clear   = is_yield && (s_src == '0) && caller.alloc && !caller.halt && caller.act;
    y_mask_f  = is_yield && ($signed(s_src) > 0) && (s_mask == '0);
    y_sched_f = is_yield && ($signed(s_src) < 0) && ($signed(s_src) != -2)
              && cfg_ysi && caller.dirty;
    halt_ok   = is_halt && caller.act;
    rest_ok   = is_rest && !caller.act;
  end

  // ---------------- restart PC storage ----------------
  logic             ram_we;
  logic [IDX_W-1:0] ram_waddr;
  logic [PC_W-1:0]  ram_rdata;

  always_comb begin
    ram_we    = fork_ok || halt_ok;
    ram_waddr = fork_ok ? pick_idx : s_ctx;
  end

  tcm_pc_ram #(.DEPTH(NCTX), .W(PC_W), .AW(IDX_W)) u_pc_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (s_a),
    .raddr (req_ctx),
    .rdata (ram_rdata)
  );

  // ---------------- per-context state update ----------------
  for (genvar g = 0; g < NCTX; g++) begin : g_ctx
    logic fork_me, self;
    assign fork_me = fork_ok && (pick_idx == IDX_W'(g));
    assign self    = (s_ctx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[g]       <= '0;
        st_q[g].alloc <= 1'b1;
      end else begin
        st_q[g].alloc <= alloc_mask[g];
        if (fork_me) begin
          st_q[g].act   <= 1'b1;
          st_q[g].dirty <= 1'b1;
          st_q[g].tds   <= 1'b0;
          st_q[g].run   <= '0;
          st_q[g].mode  <= s_mode;
          st_q[g].asid  <= s_asid;
        end
        if (y_clear && self) st_q[g].act <= 1'b0;
        if (halt_ok && self) begin
          st_q[g].act  <= 1'b0;
          st_q[g].halt <= 1'b1;
        end
        if (rest_ok && self) begin
          st_q[g].act  <= 1'b1;
          st_q[g].halt <= 1'b0;
        end
      end
    end

    assign ctx_active[g] = st_q[g].act;
    assign ctx_halted[g] = st_q[g].halt;
  end

  // ---------------- registered result outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      fault     <= 1'b0;
      exc_code  <= EXC_NONE;
      yield_res <= '0;
      wr_en     <= 1'b0;
      wr_ctx    <= '0;
      wr_rd     <= '0;
      wr_data   <= '0;
      resume_en <= 1'b0;
      resume_pc <= '0;
      peek_stat <= '0;
    end else begin
      done      <= s_vld;
      fault     <= fork_bad || y_mask_f || y_sched_f;
      exc_code  <= fork_bad  ? EXC_NOFREE :
                   y_mask_f  ? EXC_YMASK  :
                   y_sched_f ? EXC_YSCHED : EXC_NONE;
      yield_res <= is_yield ? (s_src & s_mask) : '0;
      wr_en     <= fork_ok;
      wr_ctx    <= fork_ok ? pick_idx : '0;
      wr_rd     <= fork_ok ? s_rd : '0;
      wr_data   <= fork_ok ? s_b : '0;
      resume_en <= rest_ok;
      resume_pc <= rest_ok ? ram_rdata : '0;
      peek_stat <= st_q[peek_ctx];
    end
  end

endmodule

// File: rtl/tcm_chk.sv
module tcm_chk #(
  parameter int NCTX = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            done,
  input logic            fault,
  input logic [2:0]      exc_code,
  input logic            wr_en,
  input logic            resume_en,
  input logic [NCTX-1:0] ctx_active,
  input logic [NCTX-1:0] ctx_halted
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    $fell(rst) |-> (ctx_active == '0 && ctx_halted == '0 && !done && exc_code == 3'd0));

  // R2
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(req_valid, 2));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  state_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctx_active) |-> done);

  // R5
  child_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (done && !fault));

  // R7
  nofree_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (fault && exc_code == 3'd1) |-> (!wr_en && $stable(ctx_active)));

  // R9
  exc_means_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_code != 3'd0) |-> (fault && done));

  // R12
  halted_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (ctx_halted & ctx_active) == '0);

  // R13
  resume_clean_chk: assert property (@(posedge clk) disable iff (rst)
    resume_en |-> (done && !fault && !wr_en));
endmodule

bind thread_ctx_mgr tcm_chk #(.NCTX(NCTX)) u_tcm_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .done       (done),
  .fault      (fault),
  .exc_code   (exc_code),
  .wr_en      (wr_en),
  .resume_en  (resume_en),
  .ctx_active (ctx_active),
  .ctx_halted (ctx_halted)
);

// File: tb/thread_ctx_mgr_bench.sv
module thread_ctx_mgr_bench;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [1:0]  req_ctx = '0;
  logic [31:0] req_a = '0, req_b = '0, req_src = '0, req_mask = '0;
  logic [4:0]  req_rd = '0;
  logic [1:0]  req_mode = '0;
  logic [7:0]  req_asid = '0;
  logic [1:0]  cfg_max = 2'd3;
  logic        cfg_ysi = 1'b0;
  logic [3:0]  alloc_mask = 4'b1111;
  logic [7:0]  ctx_vpe = 8'b01_00_00_00;
  logic [1:0]  peek_ctx = '0;

  logic        done, fault, wr_en, resume_en;
  logic [2:0]  exc_code;
  logic [31:0] yield_res, wr_data, resume_pc;
  logic [1:0]  wr_ctx;
  logic [4:0]  wr_rd;
  logic [3:0]  ctx_active, ctx_halted;
  logic [16:0] peek_stat;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  thread_ctx_mgr u_thread_ctx_mgr (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_ctx(req_ctx),
    .req_a(req_a), .req_b(req_b), .req_rd(req_rd), .req_src(req_src), .req_mask(req_mask),
    .req_mode(req_mode), .req_asid(req_asid), .cfg_max(cfg_max), .cfg_ysi(cfg_ysi),
    .alloc_mask(alloc_mask), .ctx_vpe(ctx_vpe), .peek_ctx(peek_ctx),
    .done(done), .fault(fault), .exc_code(exc_code), .yield_res(yield_res),
    .wr_en(wr_en), .wr_ctx(wr_ctx), .wr_rd(wr_rd), .wr_data(wr_data),
    .resume_en(resume_en), .resume_pc(resume_pc),
    .ctx_active(ctx_active), .ctx_halted(ctx_halted), .peek_stat(peek_stat)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one request, return once the done cycle is visible
  task automatic issue(input logic [1:0] op, input logic [1:0] c, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] rd, input logic [31:0] src,
                       input logic [31:0] mask, input logic [1:0] mode, input logic [7:0] asid);
    @(negedge clk);
    req_op = op; req_ctx = c; req_a = a; req_b = b; req_rd = rd;
    req_src = src; req_mask = mask; req_mode = mode; req_asid = asid;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] c, output logic [16:0] s);
    @(negedge clk);
    peek_ctx = c;
    @(negedge clk);
    s = peek_stat;
  endtask

  task automatic t_reset();
    logic [16:0] s;
    chk("R1 active", ctx_active, 4'b0000);
    chk("R1 halted", ctx_halted, 4'b0000);
    chk("R1 done", done, 1'b0);
    chk("R1 exc", exc_code, 3'd0);
    peek(2'd3, s);
    chk("R1 status ctx3", s, 17'h10000);
  endtask

  task automatic t_fork_basic();
    logic [16:0] s;
    issue(2'd0, 2'd0, 32'h100, 32'h11, 5'd1, 0, 0, 2'b01, 8'h11);
    chk("R2 done", done, 1'b1);
    chk("R3 first pick", wr_ctx, 2'd0);
    @(negedge clk);
    chk("R2 done single", done, 1'b0);
    issue(2'd0, 2'd0, 32'h1000, 32'hDEAD, 5'd7, 0, 0, 2'b10, 8'h5A);
    chk("R5 wr_en", wr_en, 1'b1);
    chk("R3 second pick", wr_ctx, 2'd1);
    chk("R5 wr_rd", wr_rd, 5'd7);
    chk("R5 wr_data", wr_data, 32'hDEAD);
    chk("R5 no fault", fault, 1'b0);
    chk("R6 active", ctx_active, 4'b0011);
    peek(2'd1, s);
    chk("R6 child status", s, {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 2'b10, 8'h5A});
  endtask

  task automatic t_fork_fail();
    alloc_mask = 4'b1011;
    issue(2'd0, 2'd0, 32'h500, 32'h5, 5'd2, 0, 0, 2'b00, 8'h00);
    chk("R7 fault", fault, 1'b1);
    chk("R7 exc", exc_code, 3'd1);
    chk("R7 no write", wr_en, 1'b0);
    chk("R7 active same", ctx_active, 4'b0011);
    alloc_mask = 4'b1111;
  endtask

  task automatic t_scan_limit();
    cfg_max = 2'd1;
    issue(2'd0, 2'd0, 32'h600, 32'h6, 5'd3, 0, 0, 2'b00, 8'h00);
    chk("R4 limited fault", exc_code, 3'd1);
    cfg_max = 2'd3;
    issue(2'd0, 2'd0, 32'h3000, 32'h33, 5'd3, 0, 0, 2'b00, 8'h33);
    chk("R4 full scan pick", wr_ctx, 2'd2);
    chk("R4 active", ctx_active, 4'b0111);
  endtask

  task automatic t_yield_zero();
    issue(2'd1, 2'd1, 0, 0, 0, 32'd0, 32'hFFFF, 2'b00, 8'h00);
    chk("R8 cleared", ctx_active, 4'b0101);
    chk("R8 no fault", fault, 1'b0);
    chk("R11 zero result", yield_res, 32'd0);
    alloc_mask = 4'b1011;
    issue(2'd1, 2'd2, 0, 0, 0, 32'd0, 32'hFFFF, 2'b00, 8'h00);
    chk("R8 non-alloc kept", ctx_active, 4'b0101);
    alloc_mask = 4'b1111;
  endtask

  task automatic t_restore();
    issue(2'd3, 2'd1, 0, 0, 0, 0, 0, 2'b00, 8'h00);
    chk("R13 resume_en", resume_en, 1'b1);
    chk("R5 restart pc via restore", resume_pc, 32'h1000);
    chk("R13 active", ctx_active, 4'b0111);
    issue(2'd3, 2'd1, 0, 0, 0, 0, 0, 2'b00, 8'h00);
    chk("R13 active restore ignored", resume_en, 1'b0);
    chk("R13 active unchanged", ctx_active, 4'b0111);
  endtask

  task automatic t_halt();
    logic [16:0] s;
    issue(2'd2, 2'd2, 32'h2468, 0, 0, 0, 0, 2'b00, 8'h00);
    chk("R12 halt active", ctx_active, 4'b0011);
    chk("R12 halt flag", ctx_halted, 4'b0100);
    peek(2'd2, s);
    chk("R12 status halt bit", s[14], 1'b1);
    issue(2'd0, 2'd0, 32'h700, 32'h7, 5'd4, 0, 0, 2'b00, 8'h00);
    chk("R3 halted skipped", exc_code, 3'd1);
    issue(2'd2, 2'd3, 32'h9999, 0, 0, 0, 0, 2'b00, 8'h00);
    chk("R12 inactive halt ignored", ctx_halted, 4'b0100);
    chk("R12 inactive halt active", ctx_active, 4'b0011);
    issue(2'd3, 2'd2, 0, 0, 0, 0, 0, 2'b00, 8'h00);
    chk("R13 resume pc", resume_pc, 32'h2468);
    chk("R13 halt cleared", ctx_halted, 4'b0000);
    chk("R13 reactivated", ctx_active, 4'b0111);
  endtask

  task automatic t_yield_pos();
    issue(2'd1, 2'd0, 0, 0, 0, 32'd5, 32'd0, 2'b00, 8'h00);
    chk("R9 fault", fault, 1'b1);
    chk("R9 exc", exc_code, 3'd2);
    chk("R11 result", yield_res, 32'd0);
    issue(2'd1, 2'd0, 0, 0, 0, 32'd5, 32'hC, 2'b00, 8'h00);
    chk("R9 no fault", fault, 1'b0);
    chk("R11 masked", yield_res, 32'd4);
  endtask

  task automatic t_yield_neg();
    cfg_ysi = 1'b1;
    issue(2'd1, 2'd1, 0, 0, 0, 32'hFFFF_FFFF, 32'hF0, 2'b00, 8'h00);
    chk("R10 fault", fault, 1'b1);
    chk("R10 exc", exc_code, 3'd4);
    chk("R11 neg result", yield_res, 32'hF0);
    chk("R10 state kept", ctx_active, 4'b0111);
    issue(2'd1, 2'd1, 0, 0, 0, 32'hFFFF_FFFE, 32'hF0, 2'b00, 8'h00);
    chk("R10 minus two", fault, 1'b0);
    issue(2'd1, 2'd3, 0, 0, 0, 32'hFFFF_FFFD, 32'hF0, 2'b00, 8'h00);
    chk("R10 clean caller", fault, 1'b0);
    cfg_ysi = 1'b0;
    issue(2'd1, 2'd1, 0, 0, 0, 32'hFFFF_FFFF, 32'hF0, 2'b00, 8'h00);
    chk("R10 disabled", fault, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fork_basic();
    t_fork_fail();
    t_scan_limit();
    t_yield_zero();
    t_restore();
    t_halt();
    t_yield_pos();
    t_yield_neg();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule